// File: doc/BRIEF.md
# Edge Interrupt and Wake Detector

This block watches a bank of already synchronized pin levels and turns chosen transitions into pending interrupt bits and wake requests. Each pin has its own enable for rising and for falling transitions. One pair of enable vectors feeds the interrupt status. A second pair, set up independently, feeds the wake logic. A transition counts as a wake event only when the pin's sleep-control bit is 0 and the chip-level sleep input is high.

Software programs the enables through a small write port with a 3-bit register select. Pending bits stay set until software writes ones to the clear register. The block drives an interrupt line that is the OR of all pending bits and a wake line. It also reports the index of the lowest pending pin, so a handler can serve pins from the lowest index upward. It detects edges only. It has no level-sensitive modes.

Top module: `edge_wake_det`

## Requirements
- R1: After reset the status vector, `irq_o`, `wake_o` and `first_vld_o` are all 0, all four edge enable vectors are 0, and every sleep-control bit is 1 (wake disabled).
- R2: A 0-to-1 change on a pin whose rising interrupt enable is 1 sets that pin's status bit. A 1-to-0 change sets it when the falling enable is 1. When both enables are 1, both directions set it. The bit is visible after the first clock edge that samples the new level.
- R3: A transition in a direction whose interrupt enable is 0 leaves the status bit unchanged. This holds even when the wake enables select that transition.
- R4: Status bits stay set until cleared. A write to select 5 clears every status bit whose data bit is 1. Data bits of 0 leave their status bits unchanged.
- R5: When a qualifying transition and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: `irq_o` is 1 exactly when at least one status bit is 1.
- R7: A transition selected by the wake rising (select 2) or wake falling (select 3) enable is latched as a wake event when it occurs while the pin's sleep-control bit (select 4) is 0 and `sleep_i` is 1. `wake_o` is 1 while `sleep_i` is 1 and any wake event is latched. A clear write (select 5) also removes the latched wake event of each cleared pin.
- R8: A wake-selected transition is not latched when the pin's sleep-control bit is 1, or when `sleep_i` is 0 at the time of the transition.
- R9: `first_vld_o` is 1 when any status bit is set. `first_idx_o` then gives the lowest set bit position.
- R10: The register selects are 0 for the rising interrupt enable, 1 for the falling interrupt enable, 2 for the wake rising enable, 3 for the wake falling enable, 4 for sleep control and 5 for clear. A write to select 6 or 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl_i | input | NPINS | Synchronized pin levels |
| sleep_i | input | 1 | Chip is in a sleep state |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select |
| wr_data_i | input | NPINS | Write data, one bit per pin |
| status_o | output | NPINS | Pending interrupt bits |
| irq_o | output | 1 | OR of all pending bits |
| wake_o | output | 1 | Wake request |
| first_idx_o | output | IDXW | Index of lowest pending pin |
| first_vld_o | output | 1 | Some pin is pending |

## Verification
The bench lets an edge and a clear of the same bit meet in one cycle. A design that gives the clear priority would lose that interrupt. It enables both directions on one pin and a single direction on others. A swapped or shared mask would then show up as an extra or missing bit. The wake tests cover four cases: the sleep-control bit set, `sleep_i` low at the time of the edge, `sleep_i` dropping after the edge, and a clear write. A latch that ignores either gate, or that the clear leaves set, raises a false wake or keeps one alive. The encoder is walked through pins 4, 9 and 31 as each one is cleared. An encoder that picks the highest bit, or that stops short of the top bit, reports the wrong index.

// File: rtl/edge_wake_pkg.sv
package edge_wake_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_RISE_IRQ  = 3'd0,
        SEL_FALL_IRQ  = 3'd1,
        SEL_RISE_WAKE = 3'd2,
        SEL_FALL_WAKE = 3'd3,
        SEL_SLEEP_CTL = 3'd4,
        SEL_CLEAR     = 3'd5
    } reg_sel_e;

    function automatic logic sel_is(input logic [SEL_W-1:0] addr, input reg_sel_e sel);
        return addr == SEL_W'(sel);
    endfunction

endpackage

// File: rtl/pin_edge_sense.sv
module pin_edge_sense #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] prev_d;
    logic [W-1:0] prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
        fall_o = ~lvl_i & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/edge_qualify.sv
module edge_qualify #(
    parameter int W = 32
) (
    input  logic [W-1:0] rise_i,
    input  logic [W-1:0] fall_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    input  logic [W-1:0] gate_i,
    output logic [W-1:0] hit_o
);

    always_comb begin
        hit_o = ((rise_i & rise_en_i) | (fall_i & fall_en_i)) & gate_i;
    end

endmodule

// File: rtl/lowest_pending.sv
module lowest_pending #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          vld_o
);

    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
            end
        end
        vld_o = |vec_i;
    end

endmodule

// File: rtl/edge_wake_det.sv
module edge_wake_det #(
    parameter int NPINS = 32,
    parameter int IDXW  = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl_i,
    input  logic             sleep_i,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_addr_i,
    input  logic [NPINS-1:0] wr_data_i,
    output logic [NPINS-1:0] status_o,
    output logic             irq_o,
    output logic             wake_o,
    output logic [IDXW-1:0]  first_idx_o,
    output logic             first_vld_o
);
    import edge_wake_pkg::*;

    typedef struct packed {
        logic [NPINS-1:0] rise_irq;
        logic [NPINS-1:0] fall_irq;
        logic [NPINS-1:0] rise_wake;
        logic [NPINS-1:0] fall_wake;
        logic [NPINS-1:0] sleep_ctl;
        logic [NPINS-1:0] status;
        logic [NPINS-1:0] wake_pend;
    } state_t;

    localparam state_t RST_VAL = '{
        rise_irq:  '0,
        fall_irq:  '0,
        rise_wake: '0,
        fall_wake: '0,
        sleep_ctl: '1,
        status:    '0,
        wake_pend: '0
    };

    state_t st_d;
    state_t st_q;

    logic [NPINS-1:0] rise_ev;
    logic [NPINS-1:0] fall_ev;
    logic [NPINS-1:0] irq_hit;
    logic [NPINS-1:0] wake_hit;
    logic [NPINS-1:0] wake_gate;
    logic [NPINS-1:0] clr_vec;
    logic [NPINS-1:0] irq_msk_any;

    pin_edge_sense #(.W(NPINS)) u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pin_lvl_i),
        .rise_o (rise_ev),
        .fall_o (fall_ev)
    );

    edge_qualify #(.W(NPINS)) u_irq_qual (
        .rise_i    (rise_ev),
        .fall_i    (fall_ev),
        .rise_en_i (st_q.rise_irq),
        .fall_en_i (st_q.fall_irq),
        .gate_i    ({NPINS{1'b1}}),
        .hit_o     (irq_hit)
    );

    assign wake_gate   = ~st_q.sleep_ctl & {NPINS{sleep_i}};
    assign irq_msk_any = st_q.rise_irq | st_q.fall_irq;

    edge_qualify #(.W(NPINS)) u_wake_qual (
        .rise_i    (rise_ev),
        .fall_i    (fall_ev),
        .rise_en_i (st_q.rise_wake),
        .fall_en_i (st_q.fall_wake),
        .gate_i    (wake_gate),
        .hit_o     (wake_hit)
    );

    lowest_pending #(.W(NPINS), .IW(IDXW)) u_first (
        .vec_i (st_q.status),
        .idx_o (first_idx_o),
        .vld_o (first_vld_o)
    );

    always_comb begin
        st_d    = st_q;
        clr_vec = (wr_en_i && sel_is(wr_addr_i, SEL_CLEAR)) ? wr_data_i : '0;
        if (wr_en_i) begin
            if (sel_is(wr_addr_i, SEL_RISE_IRQ))  st_d.rise_irq  = wr_data_i;
            if (sel_is(wr_addr_i, SEL_FALL_IRQ))  st_d.fall_irq  = wr_data_i;
            if (sel_is(wr_addr_i, SEL_RISE_WAKE)) st_d.rise_wake = wr_data_i;
            if (sel_is(wr_addr_i, SEL_FALL_WAKE)) st_d.fall_wake = wr_data_i;
            if (sel_is(wr_addr_i, SEL_SLEEP_CTL)) st_d.sleep_ctl = wr_data_i;
        end
        // a new edge outranks a clear of the same bit
        st_d.status    = (st_q.status & ~clr_vec) | irq_hit;
        st_d.wake_pend = (st_q.wake_pend & ~clr_vec) | wake_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign irq_o    = |st_q.status;
    assign wake_o   = sleep_i & (|st_q.wake_pend);

endmodule

// File: rtl/edge_wake_det_chk.sv
module edge_wake_det_chk #(
    parameter int NPINS = 32,
    parameter int IDXW  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_i,
    input logic             wr_en_i,
    input logic [2:0]       wr_addr_i,
    input logic [NPINS-1:0] status_o,
    input logic             wake_o,
    input logic [IDXW-1:0]  first_idx_o,
    input logic             first_vld_o,
    input logic [NPINS-1:0] irq_msk_any
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R4: without a clear write, no pending bit drops
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !($past(wr_en_i) && $past(wr_addr_i) == 3'd5))
        |-> ((status_o & $past(status_o)) == $past(status_o)));

    // R3: a newly set bit must have had an interrupt enable
    a_r3_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((status_o & ~$past(status_o) & ~$past(irq_msk_any)) == '0));

    // R9: the reported index is set and nothing below it is
    a_r9_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        first_vld_o |-> (status_o[first_idx_o]
            && ((status_o & ((NPINS'(1) << first_idx_o) - NPINS'(1))) == '0)));

    a_r9_valid: assert property (@(posedge clk) disable iff (!rst_n)
        first_vld_o == (status_o != '0));

    // R7: wake only while sleeping
    a_r7_wake_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> sleep_i);

endmodule

bind edge_wake_det edge_wake_det_chk #(.NPINS(NPINS), .IDXW(IDXW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .status_o    (status_o),
    .wake_o      (wake_o),
    .first_idx_o (first_idx_o),
    .first_vld_o (first_vld_o),
    .irq_msk_any (irq_msk_any)
);

// File: tb/sim_edge_wake_det.sv
`timescale 1ns/1ps
module sim_edge_wake_det;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        sleep = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] status;
    logic        irq;
    logic        wake;
    logic [4:0]  fidx;
    logic        fvld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edge_wake_det u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_lvl_i   (pins),
        .sleep_i     (sleep),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .status_o    (status),
        .irq_o       (irq),
        .wake_o      (wake),
        .first_idx_o (fidx),
        .first_vld_o (fvld)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        chk("R1 status", status, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 wake", {31'b0, wake}, 32'h0);
        chk("R1 vld", {31'b0, fvld}, 32'h0);
        // sleep control resets to ones: a wake-enabled edge in sleep must not wake
        wr(3'd2, 32'h1 << 20);
        sleep = 1'b1;
        pins[20] = 1'b1; tick();
        chk("R1 sleep_ctl ones", {31'b0, wake}, 32'h0);
        chk("R1 masks zero", status, 32'h0);
        sleep = 1'b0; pins[20] = 1'b0; tick();
        wr(3'd2, 32'h0);
    endtask

    task automatic t_edges();
        wr(3'd0, 32'h5);
        wr(3'd1, 32'h6);
        pins[0] = 1'b1; tick();
        chk("R2 rise sets", status, 32'h1);
        chk("R6 irq high", {31'b0, irq}, 32'h1);
        pins[1] = 1'b1; tick();
        chk("R3 rise disabled", status, 32'h1);
        pins[1] = 1'b0; tick();
        chk("R2 fall sets", status, 32'h3);
        pins[2] = 1'b1; tick();
        chk("R2 both rise", status, 32'h7);
        wr(3'd5, 32'h4);
        chk("R4 clear one", status, 32'h3);
        pins[2] = 1'b0; tick();
        chk("R2 both fall", status, 32'h7);
        wr(3'd5, 32'hFFFF_FFFF);
        chk("R4 clear all", status, 32'h0);
        chk("R6 irq low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_mask_off();
        pins[10] = 1'b1; tick();
        pins[10] = 1'b0; tick();
        chk("R3 unmasked pin", status, 32'h0);
    endtask

    task automatic t_zero_clear();
        pins[0] = 1'b0; tick();
        pins[0] = 1'b1; tick();
        wr(3'd5, 32'h0);
        tick(); tick();
        chk("R4 zero write keeps", status, 32'h1);
    endtask

    task automatic t_set_wins();
        pins[0] = 1'b0; tick();
        pins[0] = 1'b1;
        wr(3'd5, 32'h1);
        chk("R5 set wins", status, 32'h1);
        wr(3'd5, 32'h1);
        chk("R5 later clear", status, 32'h0);
    endtask

    task automatic t_wake();
        wr(3'd2, 32'h1 << 5);
        wr(3'd3, 32'h1 << 6);
        wr(3'd4, ~(32'h1 << 5));
        wr(3'd4, ~(32'h1 << 5) & ~(32'h1 << 7));
        sleep = 1'b1;
        pins[5] = 1'b1; tick();
        chk("R7 wake set", {31'b0, wake}, 32'h1);
        chk("R3 wake not status", status, 32'h0);
        sleep = 1'b0; #1;
        chk("R7 wake gated by sleep", {31'b0, wake}, 32'h0);
        sleep = 1'b1; #1;
        chk("R7 wake latched", {31'b0, wake}, 32'h1);
        @(negedge clk);
        wr(3'd5, 32'h1 << 5);
        chk("R7 wake cleared", {31'b0, wake}, 32'h0);
        pins[6] = 1'b1; tick();
        pins[6] = 1'b0; tick();
        chk("R8 ctl bit one", {31'b0, wake}, 32'h0);
        sleep = 1'b0;
        pins[5] = 1'b0; tick();
        pins[5] = 1'b1; tick();
        sleep = 1'b1; #1;
        chk("R8 edge while awake", {31'b0, wake}, 32'h0);
        @(negedge clk);
        sleep = 1'b0;
    endtask

    task automatic t_priority();
        wr(3'd0, 32'h8000_0210);
        pins[31] = 1'b1; pins[9] = 1'b1; pins[4] = 1'b1; tick();
        chk("R9 three pending", status, 32'h8000_0210);
        chk("R9 vld", {31'b0, fvld}, 32'h1);
        chk("R9 idx 4", {27'b0, fidx}, 32'd4);
        wr(3'd5, 32'h10);
        chk("R9 idx 9", {27'b0, fidx}, 32'd9);
        wr(3'd5, 32'h200);
        chk("R9 idx 31", {27'b0, fidx}, 32'd31);
        wr(3'd5, 32'h8000_0000);
        chk("R9 none", {31'b0, fvld}, 32'h0);
    endtask

    task automatic t_bad_addr();
        pins[9] = 1'b0; tick();
        pins[9] = 1'b1; tick();
        chk("R10 setup", status, 32'h200);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        chk("R10 no clear", status, 32'h200);
        pins[12] = 1'b1; tick();
        chk("R10 no enable", status, 32'h200);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edges();
        t_mask_off();
        t_zero_clear();
        t_set_wins();
        t_wake();
        t_priority();
        t_bad_addr();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule